// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one 16-bit timer channel. A free-running up-counter advances by one on each cycle where the count-enable input is high. Four general registers (A, B, C, D) watch the counter. Each register is set to one of two roles. As a compare register it raises a match pulse while the counter equals its value. As a capture register it stores the counter value when its capture strobe arrives. Registers C and D can also be attached as buffers behind A and B. In that case they refill the primary register on each match, or they keep the previous capture.

Registers A and B each drive a status flag, and the flags feed a maskable interrupt request. Software clears a flag with a handshake: it must read the flag as one and then write a zero to it. Stray writes therefore cannot discard an event that software never saw. The CPU uses a small word-wide register bus. `bus_rdata` always shows the addressed register. A cycle counts as a read only when `bus_rd` and `bus_word` are both high. An access with `bus_word` low is a narrow access and is ignored.

Top module: `capcmp_timer`

## Requirements
- R1: The counter resets to 0x0000 and increases by one at each clock edge where `count_en` is high, wrapping from 0xFFFF to 0x0000.
- R2: A word write to the counter (address 0) loads the written value even when `count_en` is high in the same cycle. Writes with `bus_word` low change no register.
- R3: A register in compare mode (its role bit 0) drives its `cmp_match` bit high in exactly the cycles where the counter equals its value. A match on A or B sets status bit 0 or bit 1 at the next edge.
- R4: A register in capture mode (role bit 1) loads the counter value at the edge where its `cap_strobe` bit is high. For A or B, that edge also sets the register's flag. A strobe for a register in compare mode changes nothing.
- R5: A status write (address 6) clears flag bit n only when bit n of the data is 0 and a word read of the status since the last such clearing write returned bit n as 1. Writing 1 to a bit, or writing 0 without that prior read, leaves the flag unchanged.
- R6: If a flag's set condition and its clearing write fall in the same cycle, the flag stays set. The clearing write still consumes the prior read, so a further zero write without a new read does not clear.
- R7: With buffer pairing on (control bit 4 for A/C, bit 5 for B/D) and the primary in capture mode, each strobe of the primary moves its old value into its buffer and loads the counter into the primary.
- R8: With buffer pairing on and the primary in compare mode, each compare match of the primary copies its buffer into the primary at the next edge.
- R9: `irq` is high exactly when some flag n is set and its enable (control bit 8 for A, bit 9 for B) is set.
- R10: Addresses 0 to 6 select the counter, A, B, C, D, control and status. The control word holds role bits 3:0 (A to D), pairing bits 5:4 and enable bits 9:8, and reads other bits as 0. Status bits 1:0 hold the A and B flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_en | input | 1 | Counter advance enable |
| cap_strobe | input | 4 | Capture strobes for A, B, C, D (bits 0..3) |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | High for a full-word access |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data of the addressed register |
| cmp_match | output | 4 | Compare-match indications for A..D |
| irq | output | 1 | Interrupt request |

## Verification
The case that matters most is a flag event and the software clearing write landing on the same edge. The bench first arms the flag with a status read. It then drives a capture strobe on A in the same cycle as a zero write to status. The flag must still be set afterwards. A second zero write with no fresh read must also fail to clear, and only a read followed by a write then clears it. The bench also overlaps a counter write with an active count enable and expects the written value, not the value plus one.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned CCT_AW = 3;

  localparam logic [CCT_AW-1:0] ADR_CNT  = 3'd0;
  localparam logic [CCT_AW-1:0] ADR_GRA  = 3'd1;
  localparam logic [CCT_AW-1:0] ADR_CTRL = 3'd5;
  localparam logic [CCT_AW-1:0] ADR_STAT = 3'd6;

  localparam int unsigned N_PAIR  = 2;
  localparam int unsigned N_GREG  = 2 * N_PAIR;
  localparam int unsigned CTL_BUF = 4;
  localparam int unsigned CTL_IE  = 8;

  typedef struct packed {
    logic [N_PAIR-1:0] ie;
    logic [N_PAIR-1:0] buf_en;
    logic [N_GREG-1:0] cap;
  } cct_ctrl_t;
endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_q
);
  function automatic logic [W-1:0] next_count(input logic [W-1:0] c, input logic en);
    return c + {{(W-1){1'b0}}, en};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_data;
    else            cnt_q <= next_count(cnt_q, cnt_en);
  end
endmodule

// File: rtl/cct_pair.sv
module cct_pair #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         pri_cap_mode,
  input  logic         sec_cap_mode,
  input  logic         buf_mode,
  input  logic         pri_strobe,
  input  logic         sec_strobe,
  input  logic         pri_wr,
  input  logic         sec_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pri_q,
  output logic [W-1:0] sec_q,
  output logic         pri_hit,
  output logic         sec_hit,
  output logic         pri_cap
);
  function automatic logic equal_to(input logic [W-1:0] a, input logic [W-1:0] b);
    return a == b;
  endfunction

  logic sec_cap;
  logic buf_reload;
  logic buf_shift;

  assign pri_hit    = !pri_cap_mode && equal_to(cnt, pri_q);
  assign sec_hit    = !buf_mode && !sec_cap_mode && equal_to(cnt, sec_q);
  assign pri_cap    = pri_cap_mode && pri_strobe;
  assign sec_cap    = !buf_mode && sec_cap_mode && sec_strobe;
  assign buf_reload = buf_mode && pri_hit;
  assign buf_shift  = buf_mode && pri_cap;

  always_ff @(posedge clk) begin
    if (!rst_n)          pri_q <= '0;
    else if (pri_cap)    pri_q <= cnt;
    else if (buf_reload) pri_q <= sec_q;
    else if (pri_wr)     pri_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         sec_q <= '0;
    else if (buf_shift) sec_q <= pri_q;
    else if (sec_cap)   sec_q <= cnt;
    else if (sec_wr)    sec_q <= wdata;
  end
endmodule

// File: rtl/cct_flag.sv
module cct_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic rd_ev,
  input  logic clr_wr,
  output logic flag_q
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           armed_q <= 1'b0;
    else if (clr_wr)      armed_q <= 1'b0;
    else if (rd_ev && flag_q) armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (set_ev)           flag_q <= 1'b1;
    else if (clr_wr && armed_q) flag_q <= 1'b0;
  end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import cct_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   count_en,
  input  logic [N_GREG-1:0]      cap_strobe,
  input  logic [CCT_AW-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic                   bus_word,
  input  logic [W-1:0]           bus_wdata,
  output logic [W-1:0]           bus_rdata,
  output logic [N_GREG-1:0]      cmp_match,
  output logic                   irq
);
  cct_ctrl_t         ctrl_q;
  logic              wr_ok;
  logic              rd_ok;
  logic              cnt_wr;
  logic              stat_rd;
  logic              stat_wr;
  logic [W-1:0]      cnt_q;
  logic [W-1:0]      gr_q [N_GREG];
  logic [N_GREG-1:0] gr_wr;
  logic [N_PAIR-1:0] pri_hit;
  logic [N_PAIR-1:0] sec_hit;
  logic [N_PAIR-1:0] pri_cap;
  logic [N_PAIR-1:0] flag_set;
  logic [N_PAIR-1:0] flag_wr0;
  logic [N_PAIR-1:0] flag_q;
  logic [W-1:0]      ctrl_view;
  logic [W-1:0]      stat_view;
  logic [W-1:0]      reg_a, reg_b, reg_c, reg_d;

  assign wr_ok   = bus_wr && bus_word;
  assign rd_ok   = bus_rd && bus_word;
  assign cnt_wr  = wr_ok && (bus_addr == ADR_CNT);
  assign stat_wr = wr_ok && (bus_addr == ADR_STAT);
  assign stat_rd = rd_ok && (bus_addr == ADR_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ok && bus_addr == ADR_CTRL) begin
      ctrl_q.cap    <= bus_wdata[N_GREG-1:0];
      ctrl_q.buf_en <= bus_wdata[CTL_BUF +: N_PAIR];
      ctrl_q.ie     <= bus_wdata[CTL_IE +: N_PAIR];
    end
  end

  cct_counter #(.W(W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (count_en),
    .wr_en   (cnt_wr),
    .wr_data (bus_wdata),
    .cnt_q   (cnt_q)
  );

  for (genvar g = 0; g < N_GREG; g++) begin : g_wdec
    assign gr_wr[g] = wr_ok && (bus_addr == ADR_GRA + 3'(g));
  end

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    cct_pair #(.W(W)) u_pair (
      .clk          (clk),
      .rst_n        (rst_n),
      .cnt          (cnt_q),
      .pri_cap_mode (ctrl_q.cap[p]),
      .sec_cap_mode (ctrl_q.cap[p+N_PAIR]),
      .buf_mode     (ctrl_q.buf_en[p]),
      .pri_strobe   (cap_strobe[p]),
      .sec_strobe   (cap_strobe[p+N_PAIR]),
      .pri_wr       (gr_wr[p]),
      .sec_wr       (gr_wr[p+N_PAIR]),
      .wdata        (bus_wdata),
      .pri_q        (gr_q[p]),
      .sec_q        (gr_q[p+N_PAIR]),
      .pri_hit      (pri_hit[p]),
      .sec_hit      (sec_hit[p]),
      .pri_cap      (pri_cap[p])
    );

    assign flag_set[p] = pri_hit[p] || pri_cap[p];
    assign flag_wr0[p] = stat_wr && !bus_wdata[p];

    cct_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (flag_set[p]),
      .rd_ev  (stat_rd),
      .clr_wr (flag_wr0[p]),
      .flag_q (flag_q[p])
    );

    assign cmp_match[p]        = pri_hit[p];
    assign cmp_match[p+N_PAIR] = sec_hit[p];
  end

  assign irq = |(flag_q & ctrl_q.ie);

  always_comb begin
    ctrl_view = '0;
    ctrl_view[N_GREG-1:0]       = ctrl_q.cap;
    ctrl_view[CTL_BUF +: N_PAIR] = ctrl_q.buf_en;
    ctrl_view[CTL_IE +: N_PAIR]  = ctrl_q.ie;
    stat_view = '0;
    stat_view[N_PAIR-1:0] = flag_q;
  end

  always_comb begin
    case (bus_addr)
      ADR_CNT:  bus_rdata = cnt_q;
      3'd1:     bus_rdata = gr_q[0];
      3'd2:     bus_rdata = gr_q[1];
      3'd3:     bus_rdata = gr_q[2];
      3'd4:     bus_rdata = gr_q[3];
      ADR_CTRL: bus_rdata = ctrl_view;
      ADR_STAT: bus_rdata = stat_view;
      default:  bus_rdata = '0;
    endcase
  end

  assign reg_a = gr_q[0];
  assign reg_b = gr_q[1];
  assign reg_c = gr_q[2];
  assign reg_d = gr_q[3];
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         count_en,
  input logic         bus_wr,
  input logic         bus_word,
  input logic [W-1:0] bus_wdata,
  input logic         cnt_wr,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic [W-1:0] reg_c,
  input logic [W-1:0] reg_d,
  input logic [1:0]   pri_hit,
  input logic [1:0]   pri_cap,
  input logic [1:0]   flag_set,
  input logic [1:0]   flag_wr0,
  input logic [1:0]   flag_q,
  input logic [1:0]   buf_en,
  input logic         irq
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !cnt_wr) |=> cnt_q == $past(cnt_q) + {{(W-1){1'b0}}, 1'b1});

  assert_write_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(bus_wdata));

  assert_byte_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_word && !count_en) |=> $stable(cnt_q));

  assert_match_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pri_hit[0] |=> flag_q[0]);

  assert_capture_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pri_cap[0] |=> reg_a == $past(cnt_q));

  assert_clear_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[0]) |-> $past(flag_wr0[0]));

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set[1] && flag_wr0[1]) |=> flag_q[1]);

  assert_buf_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_cap[0] && buf_en[0]) |=> reg_c == $past(reg_a));

  assert_buf_compare_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_hit[1] && buf_en[1]) |=> reg_b == $past(reg_d));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == 2'b00) |-> !irq);
endmodule

bind capcmp_timer cct_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .count_en  (count_en),
  .bus_wr    (bus_wr),
  .bus_word  (bus_word),
  .bus_wdata (bus_wdata),
  .cnt_wr    (cnt_wr),
  .cnt_q     (cnt_q),
  .reg_a     (reg_a),
  .reg_b     (reg_b),
  .reg_c     (reg_c),
  .reg_d     (reg_d),
  .pri_hit   (pri_hit),
  .pri_cap   (pri_cap),
  .flag_set  (flag_set),
  .flag_wr0  (flag_wr0),
  .flag_q    (flag_q),
  .buf_en    (ctrl_q.buf_en),
  .irq       (irq)
);

// File: tb/capcmp_timer_bench.sv
module capcmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        count_en = 1'b0;
  logic [3:0]  cap_strobe = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_word = 1'b1;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  cmp_match;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [2:0] A_CNT = 3'd0, A_A = 3'd1, A_B = 3'd2, A_C = 3'd3,
                         A_D = 3'd4, A_CTL = 3'd5, A_ST = 3'd6;

  always #4 clk = ~clk;

  capcmp_timer #(.W(16)) u_capcmp_timer (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .cap_strobe(cap_strobe),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_match(cmp_match), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic word = 1'b1);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_word = word; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_word = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_word = 1'b1; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic strobe(input logic [3:0] s);
    @(negedge clk);
    cap_strobe = s;
    @(negedge clk);
    cap_strobe = '0;
  endtask

  task automatic clear_flags();
    logic [15:0] t;
    rd(A_ST, t);
    wr(A_ST, 16'h0000);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] e;
    logic [15:0] gv [4];

    // reset state, observed while reset is held
    repeat (3) @(negedge clk);
    for (int i = 0; i < 7; i++) begin
      peek(3'(i), v);
      check("R1 reset value", v, 16'h0000);
    end
    check("R9 reset irq", irq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: register map readback
    wr(A_A, 16'h1111); wr(A_B, 16'h2222); wr(A_C, 16'h3333); wr(A_D, 16'h4444);
    wr(A_CTL, 16'h0333);
    peek(A_A, v); check("R10 reg A", v, 16'h1111);
    peek(A_B, v); check("R10 reg B", v, 16'h2222);
    peek(A_C, v); check("R10 reg C", v, 16'h3333);
    peek(A_D, v); check("R10 reg D", v, 16'h4444);
    peek(A_CTL, v); check("R10 ctrl", v, 16'h0333);
    wr(A_CTL, 16'hFFFF);
    peek(A_CTL, v); check("R10 ctrl reserved bits", v, 16'h033F);
    wr(A_CTL, 16'h0000);

    // R1: increment and wrap
    wr(A_CNT, 16'hFFFD);
    count_en = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      peek(A_CNT, v);
      e = 16'(32'hFFFD + k);
      check("R1 count step/wrap", v, e);
      if (k == 6) count_en = 1'b0;
    end

    // R2: write beats increment; narrow writes ignored
    count_en = 1'b1;
    wr(A_CNT, 16'h5000);
    peek(A_CNT, v);
    count_en = 1'b0;
    check("R2 write wins over count", v, 16'h5000);
    wr(A_A, 16'hBEEF, 1'b0);
    peek(A_A, v); check("R2 narrow write to A ignored", v, 16'h1111);
    wr(A_CNT, 16'h0777, 1'b0);
    peek(A_CNT, v); check("R2 narrow write to counter ignored", v, 16'h5000);

    // R3: compare sweep over all four registers
    gv[0] = 16'h0010; gv[1] = 16'h0012; gv[2] = 16'h0014; gv[3] = 16'h0011;
    for (int i = 0; i < 4; i++) wr(A_A + 3'(i), gv[i]);
    wr(A_CNT, 16'h000C);
    clear_flags();
    peek(A_ST, v); check("R5 flags cleared before sweep", v, 16'h0000);
    count_en = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      peek(A_CNT, v);
      e = 16'(16'h000C + k);
      if (k == 12) count_en = 1'b0;
      check("R1 sweep count", v, e);
      check("R3 match vector", cmp_match,
            {3'b0, (e == gv[3]), (e == gv[2]), (e == gv[1]), (e == gv[0])});
    end
    peek(A_ST, v); check("R3 flags after sweep", v, 16'h0003);

    // R9: interrupt enables
    wr(A_CTL, 16'h0100); #1 check("R9 irq A enabled", irq, 1'b1);
    wr(A_CTL, 16'h0000); #1 check("R9 irq none enabled", irq, 1'b0);
    wr(A_CTL, 16'h0300);

    // R5: clearing handshake
    wr(A_ST, 16'h0000);
    peek(A_ST, v); check("R5 zero write without read", v, 16'h0003);
    rd(A_ST, v); check("R5 status read", v, 16'h0003);
    wr(A_ST, 16'h0003);
    peek(A_ST, v); check("R5 write of ones", v, 16'h0003);
    wr(A_ST, 16'h0002);
    peek(A_ST, v); check("R5 clear A only", v, 16'h0002);
    #1 check("R9 irq from B", irq, 1'b1);
    wr(A_CTL, 16'h0100); #1 check("R9 irq B masked", irq, 1'b0);
    wr(A_ST, 16'h0000);
    peek(A_ST, v); check("R5 clear B with kept read", v, 16'h0000);

    // R4: capture, and strobe ignored in compare mode
    wr(A_CTL, 16'h0005);
    wr(A_CNT, 16'h1234);
    strobe(4'b0111);
    peek(A_A, v); check("R4 capture A", v, 16'h1234);
    peek(A_B, v); check("R4 strobe ignored on compare B", v, 16'h0012);
    peek(A_C, v); check("R4 capture C", v, 16'h1234);
    peek(A_ST, v); check("R4 flag A set", v, 16'h0001);

    // R6: set and clear in the same cycle
    rd(A_ST, v);
    @(negedge clk);
    bus_addr = A_ST; bus_wdata = 16'h0000; bus_word = 1'b1; bus_wr = 1'b1;
    cap_strobe = 4'b0001;
    @(negedge clk);
    bus_wr = 1'b0; cap_strobe = '0;
    peek(A_ST, v); check("R6 flag kept on collision", v, 16'h0001);
    wr(A_ST, 16'h0000);
    peek(A_ST, v); check("R6 read consumed by collision", v, 16'h0001);
    clear_flags();
    peek(A_ST, v); check("R5 clear after fresh read", v, 16'h0000);

    // R7: buffered capture
    wr(A_CTL, 16'h0011);
    wr(A_A, 16'hAAAA);
    wr(A_CNT, 16'h2222);
    strobe(4'b0001);
    peek(A_A, v); check("R7 A gets counter", v, 16'h2222);
    peek(A_C, v); check("R7 C gets old A", v, 16'hAAAA);
    wr(A_CNT, 16'h3333);
    strobe(4'b0001);
    peek(A_A, v); check("R7 A second capture", v, 16'h3333);
    peek(A_C, v); check("R7 C second shift", v, 16'h2222);

    // R8: buffered compare
    wr(A_CTL, 16'h0020);
    clear_flags();
    wr(A_B, 16'h0040);
    wr(A_D, 16'h0055);
    wr(A_CNT, 16'h003E);
    count_en = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      #1;
      if (k == 2) check("R8 match B at 0x40", cmp_match[1], 1'b1);
      if (k == 3) count_en = 1'b0;
    end
    peek(A_B, v); check("R8 B reloaded from D", v, 16'h0055);
    peek(A_D, v); check("R8 D unchanged", v, 16'h0055);
    peek(A_ST, v); check("R8 flag B set", v[1], 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule